// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Acknowledge Unit

This block joins two eight-line interrupt controllers, an upper (master) and a lower (slave), into one sixteen-line source for a processor. Global lines 0–7 feed the master and lines 8–15 feed the slave. The slave's output is latched onto master line 2, so master line 2 takes no external request. Each controller has a request register, an in-service register, an enable mask and a per-line trigger selection. The trigger selection is limited by a fixed per-controller mask.

The processor sees a single interrupt output. It runs an acknowledge as a one-cycle request and gets back an 8-bit vector one cycle later. The vector is formed from the programmed base of whichever controller supplied the line. If no valid line remains, line 7 takes its place. As an alternative to acknowledging, software can poll either controller alone, or poll both with a single combined request. A combinational translator maps any global line number to its vector.

Both the acknowledge and poll requests and their result strobes are valid-only. The unit never stalls a request and cannot be held off. The consumer must take each result in the cycle its strobe is high.

Top module: `pic_cascade_ack`

## Requirements
- R1: On an edge-triggered line, a rising input sets the pending bit at the next clock. The bit stays set after the input falls, until an acknowledge or a poll clears it.
- R2: A line whose trigger bit is 1 is level-triggered: its pending bit follows the input, and an acknowledge does not clear it. Trigger bits outside the fixed masks (0xF8 master, 0xDE slave; bit n is line n) are ignored, so those lines stay edge-triggered.
- R3: Lower line numbers have higher priority. A pending, enabled line (its mask bit is 0) is deliverable only when its number is lower than every line in service. `int_out` is high exactly when the master has a deliverable line.
- R4: While the slave has a deliverable line and is not being acknowledged or polled, master line 2 is set pending. That pending bit stays latched even if the slave later stops requesting.
- R5: One cycle after `ack_req`, `vec_valid` pulses. If the master had no deliverable line, `vec_out` is master base + 7 and no state changes.
- R6: If the master's winner is line 2, the slave is acknowledged as well and `vec_out` is slave base + slave line. If the slave has no deliverable line, the vector is slave base + 7.
- R7: Otherwise `vec_out` is master base + master line. That line is marked in service, and if it is edge-triggered its pending bit is cleared.
- R8: A pulse on `eoi_valid` clears in-service bit `eoi_line` of the slave (`eoi_slave`=1) or of the master (`eoi_slave`=0).
- R9: A poll (`poll_sel` 0 = master, 1 = slave, 3 behaves as 0) returns the winning line 0–7 in `poll_data` one cycle later and clears that line's pending and in-service bits. If nothing is deliverable it returns 7 and clears nothing. A slave poll that finds a line also clears master line 2.
- R10: A combined poll (`poll_sel` 2) polls the master. If the master answers 2, it then polls the slave and returns 8 + slave answer. The combined poll also sets `mst_rd_isr`.
- R11: When `ack_req` and `poll_req` fall in the same cycle, the acknowledge is carried out and the poll is dropped: it produces no `poll_valid` and changes no state.
- R12: `xlat_vec`/`xlat_ok` translate `xlat_line`. Lines 0–7 give master base + line, and lines 8–15 give slave base + (line − 8). The result is invalid for line 2, or when the selected base is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 16 | Raw request inputs, global lines 0–15 (bit 2 unused) |
| trig_cfg | input | 16 | Per-line level-trigger select, limited by the fixed masks |
| mst_imr | input | 8 | Master enable mask, 1 blocks a line |
| slv_imr | input | 8 | Slave enable mask, 1 blocks a line |
| mst_base | input | 8 | Master vector base, 0xFF means unprogrammed |
| slv_base | input | 8 | Slave vector base, 0xFF means unprogrammed |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_slave | input | 1 | End-of-interrupt target, 1 = slave |
| eoi_line | input | 3 | Line whose in-service bit is cleared |
| ack_req | input | 1 | One-cycle acknowledge request |
| poll_req | input | 1 | One-cycle poll request |
| poll_sel | input | 2 | Poll target: 0 master, 1 slave, 2 combined |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Acknowledge result strobe |
| vec_out | output | 8 | Acknowledge vector |
| poll_valid | output | 1 | Poll result strobe |
| poll_data | output | 8 | Poll result |
| mst_rd_isr | output | 1 | Master read-select now points at in-service register |
| xlat_line | input | 4 | Global line to translate |
| xlat_vec | output | 8 | Translated vector |
| xlat_ok | output | 1 | Translated vector is valid |

## Verification
The collision that matters is an acknowledge and a poll landing on the same clock edge. Both would consume the same winning line. The bench pends master line 4, then raises `ack_req` and `poll_req` together for one cycle. It expects only the acknowledge vector in its queue, so an unexpected poll strobe shows up as a scoreboard failure. A follow-up master poll must then return 7, because the acknowledged line is in service and its pending bit has gone.

// File: rtl/pic_cas_pkg.sv
package pic_cas_pkg;
  localparam int CTL_LINES = 8;
  localparam int LINE_W = $clog2(CTL_LINES);
  localparam int CASC_LINE = 2;
  localparam int SPUR_LINE = 7;
  localparam logic [7:0] UNPROG_BASE = 8'hFF;

  typedef enum logic [1:0] {
    POLL_MST = 2'd0,
    POLL_SLV = 2'd1,
    POLL_CMB = 2'd2,
    POLL_ALT = 2'd3
  } poll_sel_e;
endpackage

// File: rtl/pic_cas_prio.sv
module pic_cas_prio #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  insvc,
  output logic          vld,
  output logic [LW-1:0] line
);
  int req_idx;
  int svc_idx;

  always_comb begin
    req_idx = N;
    svc_idx = N;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i])  req_idx = i;
      if (insvc[i]) svc_idx = i;
    end
    vld  = (req_idx < svc_idx);
    line = LW'(req_idx);
  end
endmodule

// File: rtl/pic_cas_core.sv
module pic_cas_core #(
  parameter int N = 8,
  parameter logic [N-1:0] TRIG_MASK = '1,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  pulse_set,
  input  logic [N-1:0]  trig_cfg,
  input  logic [N-1:0]  imr,
  input  logic          ack_vld,
  input  logic [LW-1:0] ack_line,
  input  logic          clr_vld,
  input  logic [LW-1:0] clr_line,
  input  logic          eoi_vld,
  input  logic [LW-1:0] eoi_line,
  output logic          win_vld,
  output logic [LW-1:0] win_line
);
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0] irr, isr, last_in;
  logic [N-1:0] lvl, rise, ack_oh, clr_oh, eoi_oh, irr_n, isr_n;

  always_comb begin
    lvl    = trig_cfg & TRIG_MASK;
    rise   = irq_in & ~last_in;
    ack_oh = ack_vld ? (ONE << ack_line) : '0;
    clr_oh = clr_vld ? (ONE << clr_line) : '0;
    eoi_oh = eoi_vld ? (ONE << eoi_line) : '0;
    irr_n  = (irr & ~clr_oh & ~(ack_oh & ~lvl)) | rise | pulse_set;
    irr_n  = (irr_n & ~lvl) | (irq_in & lvl);
    isr_n  = (isr & ~clr_oh & ~eoi_oh) | ack_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr     <= '0;
      isr     <= '0;
      last_in <= '0;
    end else begin
      irr     <= irr_n;
      isr     <= isr_n;
      last_in <= irq_in;
    end
  end

  pic_cas_prio #(.N(N)) u_prio (
    .pend  (irr & ~imr),
    .insvc (isr),
    .vld   (win_vld),
    .line  (win_line)
  );

  // R7
  ack_marks_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |=> isr[$past(ack_line)]);

  // R8
  eoi_clears_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_vld && !(ack_vld && ack_line == eoi_line)) |=> !isr[$past(eoi_line)]);

  // R3
  no_win_without_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (irr[win_line] && !imr[win_line]));
endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack
  import pic_cas_pkg::*;
#(
  parameter logic [7:0] MST_TRIG_MASK = 8'hF8,
  parameter logic [7:0] SLV_TRIG_MASK = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_lines,
  input  logic [15:0] trig_cfg,
  input  logic [7:0]  mst_imr,
  input  logic [7:0]  slv_imr,
  input  logic [7:0]  mst_base,
  input  logic [7:0]  slv_base,
  input  logic        eoi_valid,
  input  logic        eoi_slave,
  input  logic [2:0]  eoi_line,
  input  logic        ack_req,
  input  logic        poll_req,
  input  logic [1:0]  poll_sel,
  output logic        int_out,
  output logic        vec_valid,
  output logic [7:0]  vec_out,
  output logic        poll_valid,
  output logic [7:0]  poll_data,
  output logic        mst_rd_isr,
  input  logic [3:0]  xlat_line,
  output logic [7:0]  xlat_vec,
  output logic        xlat_ok
);
  localparam logic [CTL_LINES-1:0] CASC_OH = CTL_LINES'(1) << CASC_LINE;
  localparam logic [LINE_W-1:0] CASC_L = LINE_W'(CASC_LINE);
  localparam logic [LINE_W-1:0] SPUR_L = LINE_W'(SPUR_LINE);

  logic              m_vld, s_vld, m_casc;
  logic [LINE_W-1:0] m_line, s_line, s_ans;
  logic              do_ack, do_poll, poll_m, slv_path, cmb_sel;
  logic              m_ack_vld, s_ack_vld, m_clr_vld, s_clr_vld, s_busy;
  logic [LINE_W-1:0] m_clr_line;
  logic [CTL_LINES-1:0] m_pulse;
  logic [7:0]        vec_n, poll_n;
  poll_sel_e         psel;

  always_comb begin
    psel      = poll_sel_e'(poll_sel);
    cmb_sel   = (psel == POLL_CMB);
    do_ack    = ack_req;
    do_poll   = poll_req && !ack_req;
    m_casc    = m_vld && (m_line == CASC_L);
    s_ans     = s_vld ? s_line : SPUR_L;
    poll_m    = do_poll && (psel != POLL_SLV);
    slv_path  = do_poll && ((psel == POLL_SLV) || (cmb_sel && m_casc));
    m_ack_vld = do_ack && m_vld;
    s_ack_vld = do_ack && m_casc && s_vld;
    s_clr_vld = slv_path && s_vld;
    m_clr_vld = (poll_m && m_vld) || s_clr_vld;
    m_clr_line = (poll_m && m_vld) ? m_line : CASC_L;
    s_busy    = s_ack_vld || s_clr_vld;
    m_pulse   = (s_vld && !s_busy) ? CASC_OH : '0;

    if (!m_vld)      vec_n = mst_base + 8'(SPUR_L);
    else if (m_casc) vec_n = slv_base + 8'(s_ans);
    else             vec_n = mst_base + 8'(m_line);

    if (psel == POLL_SLV)     poll_n = 8'(s_ans);
    else if (cmb_sel && m_casc) poll_n = 8'(CTL_LINES) + 8'(s_ans);
    else                      poll_n = 8'(m_vld ? m_line : SPUR_L);
  end

  pic_cas_core #(.N(CTL_LINES), .TRIG_MASK(MST_TRIG_MASK)) u_mst (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_lines[7:0] & ~CASC_OH),
    .pulse_set (m_pulse),
    .trig_cfg  (trig_cfg[7:0]),
    .imr       (mst_imr),
    .ack_vld   (m_ack_vld),
    .ack_line  (m_line),
    .clr_vld   (m_clr_vld),
    .clr_line  (m_clr_line),
    .eoi_vld   (eoi_valid && !eoi_slave),
    .eoi_line  (eoi_line),
    .win_vld   (m_vld),
    .win_line  (m_line)
  );

  pic_cas_core #(.N(CTL_LINES), .TRIG_MASK(SLV_TRIG_MASK)) u_slv (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_lines[15:8]),
    .pulse_set ('0),
    .trig_cfg  (trig_cfg[15:8]),
    .imr       (slv_imr),
    .ack_vld   (s_ack_vld),
    .ack_line  (s_line),
    .clr_vld   (s_clr_vld),
    .clr_line  (s_line),
    .eoi_vld   (eoi_valid && eoi_slave),
    .eoi_line  (eoi_line),
    .win_vld   (s_vld),
    .win_line  (s_line)
  );

  pic_cas_xlat u_xlat (
    .line     (xlat_line),
    .mst_base (mst_base),
    .slv_base (slv_base),
    .vec      (xlat_vec),
    .ok       (xlat_ok)
  );

  assign int_out = m_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid  <= 1'b0;
      vec_out    <= '0;
      poll_valid <= 1'b0;
      poll_data  <= '0;
      mst_rd_isr <= 1'b0;
    end else begin
      vec_valid  <= do_ack;
      poll_valid <= do_poll;
      if (do_ack)  vec_out   <= vec_n;
      if (do_poll) poll_data <= poll_n;
      if (do_poll && cmb_sel) mst_rd_isr <= 1'b1;
    end
  end

  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && poll_valid));

  // R5
  mst_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !m_vld) |=> (vec_valid && vec_out == $past(mst_base) + 8'd7));

  // R6
  slv_spur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && m_casc && !s_vld) |=> (vec_out == $past(slv_base) + 8'd7));

  // R12
  xlat_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_line == 4'd2) |-> !xlat_ok);
endmodule

// File: rtl/pic_cas_xlat.sv
module pic_cas_xlat
  import pic_cas_pkg::*;
(
  input  logic [3:0] line,
  input  logic [7:0] mst_base,
  input  logic [7:0] slv_base,
  output logic [7:0] vec,
  output logic       ok
);
  logic       hi;
  logic [7:0] base;

  always_comb begin
    hi   = line[3];
    base = hi ? slv_base : mst_base;
    vec  = base + {5'd0, line[2:0]};
    ok   = (base != UNPROG_BASE) && !(!hi && line[2:0] == 3'(CASC_LINE));
  end
endmodule

// File: tb/sim_pic_cascade_ack.sv
module sim_pic_cascade_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [15:0] trig_cfg = '0;
  logic [7:0]  mst_imr = '0, slv_imr = '0;
  logic [7:0]  mst_base = 8'hFF, slv_base = 8'hFF;
  logic        eoi_valid = 1'b0, eoi_slave = 1'b0;
  logic [2:0]  eoi_line = '0;
  logic        ack_req = 1'b0, poll_req = 1'b0;
  logic [1:0]  poll_sel = '0;
  logic [3:0]  xlat_line = '0;
  logic        int_out, vec_valid, poll_valid, mst_rd_isr, xlat_ok;
  logic [7:0]  vec_out, poll_data, xlat_vec;

  int total = 0;
  int bad = 0;

  typedef struct {
    bit         is_poll;
    logic [7:0] data;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  pic_cascade_ack u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .trig_cfg(trig_cfg),
    .mst_imr(mst_imr), .slv_imr(slv_imr), .mst_base(mst_base), .slv_base(slv_base),
    .eoi_valid(eoi_valid), .eoi_slave(eoi_slave), .eoi_line(eoi_line),
    .ack_req(ack_req), .poll_req(poll_req), .poll_sel(poll_sel),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
    .poll_valid(poll_valid), .poll_data(poll_data), .mst_rd_isr(mst_rd_isr),
    .xlat_line(xlat_line), .xlat_vec(xlat_vec), .xlat_ok(xlat_ok)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result strobe shows up
  always @(negedge clk) begin
    if (rst_n) begin
      if (vec_valid) begin
        total++;
        if (exp_q.size() == 0 || exp_q[0].is_poll) begin
          bad++;
          $display("FAIL unexpected vector actual=%h expected=none", vec_out);
        end else begin
          if (vec_out !== exp_q[0].data) begin
            bad++;
            $display("FAIL %s vector actual=%h expected=%h", exp_q[0].tag, vec_out, exp_q[0].data);
          end
          void'(exp_q.pop_front());
        end
      end
      if (poll_valid) begin
        total++;
        if (exp_q.size() == 0 || !exp_q[0].is_poll) begin
          bad++;
          $display("FAIL R11 unexpected poll actual=%h expected=none", poll_data);
        end else begin
          if (poll_data !== exp_q[0].data) begin
            bad++;
            $display("FAIL %s poll actual=%h expected=%h", exp_q[0].tag, poll_data, exp_q[0].data);
          end
          void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_line(input int n);
    irq_lines[n] = 1'b1;
    @(negedge clk);
    irq_lines[n] = 1'b0;
    idle(3);
  endtask

  task automatic do_ack(input logic [7:0] exp, input string tag);
    ack_req = 1'b1;
    exp_q.push_back('{1'b0, exp, tag});
    @(negedge clk);
    ack_req = 1'b0;
  endtask

  task automatic do_poll(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    poll_req = 1'b1;
    poll_sel = sel;
    exp_q.push_back('{1'b1, exp, tag});
    @(negedge clk);
    poll_req = 1'b0;
  endtask

  task automatic do_eoi(input logic slv, input logic [2:0] ln);
    eoi_valid = 1'b1;
    eoi_slave = slv;
    eoi_line  = ln;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic xl(input logic [3:0] ln, input logic ok, input logic [7:0] v, input string tag);
    xlat_line = ln;
    #1;
    chk(tag, {7'd0, xlat_ok}, {7'd0, ok});
    if (ok) chk(tag, xlat_vec, v);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R3 reset int_out", {7'd0, int_out}, 8'd0);
    chk("R5 reset vec_valid", {7'd0, vec_valid}, 8'd0);
    chk("R9 reset poll_valid", {7'd0, poll_valid}, 8'd0);
    chk("R10 reset rd_isr", {7'd0, mst_rd_isr}, 8'd0);
    // R12 unprogrammed bases
    xl(4'd3, 1'b0, 8'h00, "R12 master base FF");
    xl(4'd10, 1'b0, 8'h00, "R12 slave base FF");
    mst_base = 8'h20;
    slv_base = 8'h70;
    xl(4'd0, 1'b1, 8'h20, "R12 line0");
    xl(4'd2, 1'b0, 8'h00, "R12 line2 invalid");
    xl(4'd10, 1'b1, 8'h72, "R12 line10");
    xl(4'd15, 1'b1, 8'h77, "R12 line15");

    // R5 spurious master
    do_ack(8'h27, "R5 empty ack");

    // R1 R3 R7 R8 priority and nesting
    irq_lines[5] = 1'b1; irq_lines[3] = 1'b1;
    @(negedge clk);
    irq_lines[5] = 1'b0; irq_lines[3] = 1'b0;
    idle(2);
    chk("R1 edge latched int_out", {7'd0, int_out}, 8'd1);
    do_ack(8'h23, "R3 line3 beats line5");
    chk("R3 blocked by in-service", {7'd0, int_out}, 8'd0);
    do_ack(8'h27, "R3 lower line blocked");
    do_eoi(1'b0, 3'd3);
    chk("R8 eoi releases line5", {7'd0, int_out}, 8'd1);
    do_ack(8'h25, "R7 line5 vector");
    do_eoi(1'b0, 3'd5);
    idle(1);

    // R4 R6 cascade
    pulse_line(12);
    chk("R4 cascade raises int_out", {7'd0, int_out}, 8'd1);
    do_ack(8'h74, "R6 slave line4");
    idle(1);
    chk("R6 slave consumed", {7'd0, int_out}, 8'd0);
    do_eoi(1'b1, 3'd4);
    do_eoi(1'b0, 3'd2);

    // R4 latch persists, R6 slave spurious
    pulse_line(9);
    slv_imr = 8'h02;
    idle(2);
    chk("R4 cascade latched", {7'd0, int_out}, 8'd1);
    do_ack(8'h77, "R6 slave spurious");
    do_eoi(1'b0, 3'd2);
    slv_imr = 8'h00;
    idle(3);
    do_ack(8'h71, "R6 slave line1 after unmask");
    do_eoi(1'b1, 3'd1);
    do_eoi(1'b0, 3'd2);
    idle(1);

    // R9 master poll
    pulse_line(6);
    do_poll(2'd0, 8'd6, "R9 master poll");
    do_poll(2'd0, 8'd7, "R9 master poll empty");
    chk("R9 poll cleared", {7'd0, int_out}, 8'd0);

    // R9 slave poll also clears master line 2
    pulse_line(11);
    do_poll(2'd1, 8'd3, "R9 slave poll");
    idle(2);
    chk("R9 master line2 cleared", {7'd0, int_out}, 8'd0);

    // R10 combined poll
    pulse_line(13);
    do_poll(2'd2, 8'd13, "R10 combined slave");
    chk("R10 read select", {7'd0, mst_rd_isr}, 8'd1);
    idle(2);
    pulse_line(1);
    do_poll(2'd2, 8'd1, "R10 combined master");
    do_poll(2'd2, 8'd7, "R10 combined empty");

    // R11 ack and poll collide
    pulse_line(4);
    ack_req = 1'b1; poll_req = 1'b1; poll_sel = 2'd0;
    exp_q.push_back('{1'b0, 8'h24, "R11 ack wins"});
    @(negedge clk);
    ack_req = 1'b0; poll_req = 1'b0;
    chk("R11 no poll strobe", {7'd0, poll_valid}, 8'd0);
    do_poll(2'd0, 8'd7, "R11 poll dropped, line taken");
    do_eoi(1'b0, 3'd4);

    // R2 level line stays pending
    trig_cfg[4] = 1'b1;
    irq_lines[4] = 1'b1;
    idle(2);
    do_ack(8'h24, "R2 level first");
    do_eoi(1'b0, 3'd4);
    do_ack(8'h24, "R2 level repeats");
    do_eoi(1'b0, 3'd4);
    irq_lines[4] = 1'b0;
    idle(2);
    chk("R2 level drop", {7'd0, int_out}, 8'd0);
    trig_cfg[4] = 1'b0;
    // R2 masked trigger bit stays edge
    trig_cfg[1] = 1'b1;
    irq_lines[1] = 1'b1;
    idle(2);
    do_ack(8'h21, "R2 masked line first");
    do_eoi(1'b0, 3'd1);
    do_ack(8'h27, "R2 masked line is edge");
    irq_lines[1] = 1'b0;
    trig_cfg[1] = 1'b0;
    idle(1);

    // R3 enable mask
    mst_imr = 8'h08;
    pulse_line(3);
    chk("R3 masked line quiet", {7'd0, int_out}, 8'd0);
    do_ack(8'h27, "R3 masked ack spurious");
    mst_imr = 8'h00;
    idle(1);
    do_ack(8'h23, "R3 unmasked line3");
    do_eoi(1'b0, 3'd3);

    idle(3);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R5 missing results actual=%0d expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule